// File: doc/BRIEF.md
# Microcode Branch Address Sequencer

This block produces the address of the next microinstruction for a microprogrammed controller and holds the status flags that microcode branches test. On every clock edge, which is one microcycle, it concatenates a fixed upper address field taken from the current microword with two low bits. Each low bit is chosen by its own three-bit condition selector. In the same cycle, a four-bit status-control field sets, clears or conditionally sets the general status flags S0 to S3 and the overflow, keyboard and parity-error flags.

Branch conditions always read the flag values held before the clock edge. A flag written by the status field is therefore first visible to a branch one microcycle later. One overflow test is destructive: it consumes the overflow flag as it reads it. The keyboard flag is raised from outside through a set input. The ALU zero indication, the carry, the saved carry and the Q flag arrive as plain inputs.

Top module: `bseq_sequencer`

## Requirements
- R1: The registered address `uaddr` equals {fix_addr, H, L}, with fix_addr in the upper bits and L in bit 0. It updates on every clock edge that is not in reset.
- R2: The high bit H is chosen by `hsel`: 000 gives 0, 001 gives 1, 010 gives S1, 011 gives S3, 100 gives overflow, 101 gives `carry`, 110 gives the keyboard flag, and 111 gives 0.
- R3: When `hsel` is 100, H takes the overflow flag and the flag is cleared at the same edge. If `stat_op` is 1100 in that cycle, the flag ends up set.
- R4: The low bit L is chosen by `lsel`: 000 gives 0, 001 gives 1, 010 gives S0, 011 gives S2, 100 gives `alu_zero` of the same cycle, 101 gives `q_flag`, 110 gives `sav_carry`, and 111 gives 0.
- R5: `stat_op` values 0001, 0010, 0011 and 0100 set S0, S1, S2 and S3. Values 0101, 0110, 0111 and 1000 clear S0, S1, S2 and S3. Value 1101 clears all four.
- R6: `stat_op` 1010 sets S0 only when `alu_zero` is 0. `stat_op` 1011 sets S1 only when `alu_zero` is 1. Otherwise neither code changes any flag.
- R7: `stat_op` 1001 clears the keyboard flag, and `kbd_set` sets it; when both occur in one cycle the flag ends up set. `stat_op` 1100 sets overflow. `stat_op` 1110 sets parity error, which then stays set until reset.
- R8: `stat_op` 0000 and 1111 leave every flag unchanged, apart from the effects of `hsel` 100 and `kbd_set`.
- R9: The branch tests read flag values from before the edge. A flag changed by `stat_op` in a cycle does not affect that same cycle's H or L.
- R10: Synchronous active-high reset clears `uaddr` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per microcycle |
| rst | input | 1 | Synchronous active-high reset |
| fix_addr | input | 9 | Fixed upper field of the next address |
| hsel | input | 3 | Condition selector for address bit 1 |
| lsel | input | 3 | Condition selector for address bit 0 |
| stat_op | input | 4 | Status-control code |
| alu_zero | input | 1 | ALU output is all zeros |
| carry | input | 1 | Carry flag |
| sav_carry | input | 1 | Saved carry flag |
| q_flag | input | 1 | Q flag |
| kbd_set | input | 1 | Raise the keyboard flag |
| uaddr | output | 11 | Registered next microinstruction address |
| sflags | output | 4 | Status flags S3..S0 |
| ovf | output | 1 | Overflow flag |
| kbd | output | 1 | Keyboard flag |
| perr | output | 1 | Parity-error flag |

## Verification
Directed patterns step each selector through all eight codes. Before each test, the flag it reads is set so that a copied flag and a forced constant give different results. The directed patterns also drive every status code against flags preset to the opposite value, which makes each set, clear and no-op visible. Dedicated cycles combine a status write with a branch on the same flag. They also combine an overflow test with an overflow set, and a keyboard clear with a keyboard set, which separates pre-edge reads from post-edge reads and shows which side wins each collision. A long run of pseudo-random microwords then checks that the selectors and the status field interact correctly under arbitrary combinations.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int SEL_W  = 3;
    localparam int OP_W   = 4;
    localparam int NSTAT  = 4;

    typedef enum logic [SEL_W-1:0] {
        H_ZERO  = 3'd0,
        H_ONE   = 3'd1,
        H_S1    = 3'd2,
        H_S3    = 3'd3,
        H_OVF   = 3'd4,
        H_CARRY = 3'd5,
        H_KBD   = 3'd6,
        H_NONE  = 3'd7
    } hsel_e;

    typedef enum logic [SEL_W-1:0] {
        L_ZERO  = 3'd0,
        L_ONE   = 3'd1,
        L_S0    = 3'd2,
        L_S2    = 3'd3,
        L_ALUZ  = 3'd4,
        L_Q     = 3'd5,
        L_SAVC  = 3'd6,
        L_NONE  = 3'd7
    } lsel_e;

    typedef enum logic [OP_W-1:0] {
        ST_IDLE    = 4'd0,
        ST_SET_S0  = 4'd1,
        ST_CLR_S0  = 4'd5,
        ST_CLR_KBD = 4'd9,
        ST_SET_NZ  = 4'd10,
        ST_SET_Z   = 4'd11,
        ST_SET_OVF = 4'd12,
        ST_CLR_ALL = 4'd13,
        ST_SET_PE  = 4'd14,
        ST_SPARE   = 4'd15
    } stop_e;

    typedef struct packed {
        logic             perr;
        logic             kbd;
        logic             ovf;
        logic [NSTAT-1:0] s;
    } flags_t;

    // Code that sets general flag idx; the clearing codes follow the setting ones
    function automatic logic [OP_W-1:0] set_code(input int idx);
        return OP_W'(int'(ST_SET_S0) + idx);
    endfunction

    function automatic logic [OP_W-1:0] clr_code(input int idx);
        return OP_W'(int'(ST_CLR_S0) + idx);
    endfunction

endpackage

// File: rtl/bseq_hi_cond.sv
module bseq_hi_cond
    import bseq_pkg::*;
(
    input  hsel_e  sel,
    input  flags_t flg,
    input  logic   carry,
    output logic   bit_out
);
    always_comb begin
        unique case (sel)
            H_ZERO:  bit_out = 1'b0;
            H_ONE:   bit_out = 1'b1;
            H_S1:    bit_out = flg.s[1];
            H_S3:    bit_out = flg.s[3];
            H_OVF:   bit_out = flg.ovf;
            H_CARRY: bit_out = carry;
            H_KBD:   bit_out = flg.kbd;
            default: bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/bseq_lo_cond.sv
module bseq_lo_cond
    import bseq_pkg::*;
(
    input  lsel_e  sel,
    input  flags_t flg,
    input  logic   alu_zero,
    input  logic   q_flag,
    input  logic   sav_carry,
    output logic   bit_out
);
    always_comb begin
        unique case (sel)
            L_ZERO:  bit_out = 1'b0;
            L_ONE:   bit_out = 1'b1;
            L_S0:    bit_out = flg.s[0];
            L_S2:    bit_out = flg.s[2];
            L_ALUZ:  bit_out = alu_zero;
            L_Q:     bit_out = q_flag;
            L_SAVC:  bit_out = sav_carry;
            default: bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/bseq_status.sv
module bseq_status
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic              alu_zero,
    input  logic              ovf_take,
    input  logic              kbd_set,
    output flags_t            flg
);
    flags_t nxt;

    always_comb begin
        nxt = flg;
        for (int i = 0; i < NSTAT; i++) begin
            if (op == set_code(i))
                nxt.s[i] = 1'b1;
            else if (op == clr_code(i) || op == ST_CLR_ALL)
                nxt.s[i] = 1'b0;
        end
        if (op == ST_SET_NZ && !alu_zero)
            nxt.s[0] = 1'b1;
        if (op == ST_SET_Z && alu_zero)
            nxt.s[1] = 1'b1;
        // destructive overflow test clears; a set in the same cycle wins
        if (op == ST_SET_OVF)
            nxt.ovf = 1'b1;
        else if (ovf_take)
            nxt.ovf = 1'b0;
        // peripheral request wins over a clear in the same cycle
        if (kbd_set)
            nxt.kbd = 1'b1;
        else if (op == ST_CLR_KBD)
            nxt.kbd = 1'b0;
        if (op == ST_SET_PE)
            nxt.perr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flg <= '0;
        else
            flg <= nxt;
    end
endmodule

// File: rtl/bseq_sequencer.sv
module bseq_sequencer
    import bseq_pkg::*;
#(
    parameter int FIX_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FIX_W-1:0]  fix_addr,
    input  logic [2:0]        hsel,
    input  logic [2:0]        lsel,
    input  logic [3:0]        stat_op,
    input  logic              alu_zero,
    input  logic              carry,
    input  logic              sav_carry,
    input  logic              q_flag,
    input  logic              kbd_set,
    output logic [FIX_W+1:0]  uaddr,
    output logic [3:0]        sflags,
    output logic              ovf,
    output logic              kbd,
    output logic              perr
);
    localparam int ADDR_W = FIX_W + 2;

    flags_t flg;
    logic   h_bit;
    logic   l_bit;
    hsel_e  hs;
    lsel_e  ls;

    assign hs = hsel_e'(hsel);
    assign ls = lsel_e'(lsel);

    bseq_hi_cond u_hi (
        .sel     (hs),
        .flg     (flg),
        .carry   (carry),
        .bit_out (h_bit)
    );

    bseq_lo_cond u_lo (
        .sel       (ls),
        .flg       (flg),
        .alu_zero  (alu_zero),
        .q_flag    (q_flag),
        .sav_carry (sav_carry),
        .bit_out   (l_bit)
    );

    bseq_status u_st (
        .clk      (clk),
        .rst      (rst),
        .op       (stat_op),
        .alu_zero (alu_zero),
        .ovf_take (hs == H_OVF),
        .kbd_set  (kbd_set),
        .flg      (flg)
    );

    always_ff @(posedge clk) begin
        if (rst)
            uaddr <= '0;
        else
            uaddr <= ADDR_W'({fix_addr, h_bit, l_bit});
    end

    assign sflags = flg.s;
    assign ovf    = flg.ovf;
    assign kbd    = flg.kbd;
    assign perr   = flg.perr;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int FIX_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [FIX_W-1:0]  fix_addr,
    input logic [2:0]        hsel,
    input logic [2:0]        lsel,
    input logic [3:0]        stat_op,
    input logic              alu_zero,
    input logic              kbd_set,
    input logic [FIX_W+1:0]  uaddr,
    input logic [3:0]        sflags,
    input logic              ovf,
    input logic              perr
);
    p_fixed_field_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> uaddr[FIX_W+1:2] == $past(fix_addr));

    p_h_force_one_r2: assert property (@(posedge clk) disable iff (rst)
        hsel == 3'b001 |=> uaddr[1]);

    p_h_reads_s1_r9: assert property (@(posedge clk) disable iff (rst)
        hsel == 3'b010 |=> uaddr[1] == $past(sflags[1]));

    p_ovf_consumed_r3: assert property (@(posedge clk) disable iff (rst)
        (hsel == 3'b100 && stat_op != 4'b1100) |=> !ovf);

    p_l_alu_zero_r4: assert property (@(posedge clk) disable iff (rst)
        lsel == 3'b100 |=> uaddr[0] == $past(alu_zero));

    p_l_undef_r4: assert property (@(posedge clk) disable iff (rst)
        lsel == 3'b111 |=> !uaddr[0]);

    p_set_s2_r5: assert property (@(posedge clk) disable iff (rst)
        stat_op == 4'b0011 |=> sflags[2]);

    p_clear_all_r5: assert property (@(posedge clk) disable iff (rst)
        stat_op == 4'b1101 |=> sflags == 4'b0000);

    p_cond_nz_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_op == 4'b1010 && !alu_zero) |=> sflags[0]);

    p_perr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        perr |=> perr);

    p_idle_flags_r8: assert property (@(posedge clk) disable iff (rst)
        stat_op == 4'b0000 |=> $stable(sflags));
endmodule

bind bseq_sequencer bseq_checker #(.FIX_W(FIX_W)) u_chk (.*);

// File: tb/sim_bseq_sequencer.sv
module sim_bseq_sequencer;
    localparam int FW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [FW-1:0] fix_addr = '0;
    logic [2:0] hsel = '0, lsel = '0;
    logic [3:0] stat_op = '0;
    logic alu_zero = 0, carry = 0, sav_carry = 0, q_flag = 0, kbd_set = 0;
    logic [FW+1:0] uaddr;
    logic [3:0] sflags;
    logic ovf, kbd, perr;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    int m_addr = 0;
    bit m_s[4];
    bit m_ovf, m_kbd, m_perr;

    always #10 clk = ~clk;

    bseq_sequencer #(.FIX_W(FW)) u0 (.*);

    function automatic int m_flags();
        return m_s[0] + 2 * m_s[1] + 4 * m_s[2] + 8 * m_s[3];
    endfunction

    task automatic check(input string tag, input int got, input int exp, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, int'(uaddr), m_addr, "uaddr");
        check(tag, int'({perr, kbd, ovf, sflags}),
              m_perr * 64 + m_kbd * 32 + m_ovf * 16 + m_flags(), "flags");
    endtask

    // one microcycle: drive at falling edge, model, compare at next falling edge
    task automatic cyc(input int f, input int hs, input int ls, input int op,
                       input bit z, input bit c, input bit sc, input bit q,
                       input bit ks, input string tag);
        bit h, l;
        fix_addr = FW'(f); hsel = 3'(hs); lsel = 3'(ls); stat_op = 4'(op);
        alu_zero = z; carry = c; sav_carry = sc; q_flag = q; kbd_set = ks;
        case (hs)
            1: h = 1;
            2: h = m_s[1];
            3: h = m_s[3];
            4: h = m_ovf;
            5: h = c;
            6: h = m_kbd;
            default: h = 0;
        endcase
        case (ls)
            1: l = 1;
            2: l = m_s[0];
            3: l = m_s[2];
            4: l = z;
            5: l = q;
            6: l = sc;
            default: l = 0;
        endcase
        m_addr = f * 4 + h * 2 + l;
        if (op >= 1 && op <= 4) m_s[op-1] = 1;
        if (op >= 5 && op <= 8) m_s[op-5] = 0;
        if (op == 13) begin m_s[0] = 0; m_s[1] = 0; m_s[2] = 0; m_s[3] = 0; end
        if (op == 10 && !z) m_s[0] = 1;
        if (op == 11 && z) m_s[1] = 1;
        if (hs == 4) m_ovf = 0;
        if (op == 12) m_ovf = 1;
        if (op == 9) m_kbd = 0;
        if (ks) m_kbd = 1;
        if (op == 14) m_perr = 1;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic st(input int op, input string tag);
        cyc(0, 0, 0, op, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        compare("R10");
        rst = 0;

        // R1 address composition
        cyc(9'h1A5, 1, 1, 0, 0, 0, 0, 0, 0, "R1");
        cyc(9'h000, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        cyc(9'h0FF, 1, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R5 set and clear each general flag
        for (int i = 1; i <= 4; i++) st(i, "R5");
        for (int i = 5; i <= 8; i++) st(i, "R5");
        st(1, "R5"); st(3, "R5"); st(13, "R5");

        // R2 each high selector code with flags set
        st(2, "R2"); st(4, "R2"); st(12, "R2");
        cyc(3, 6, 0, 0, 0, 0, 0, 0, 1, "R7");
        for (int k = 0; k < 8; k++) cyc(k + 16, k, 0, 0, 0, 1, 0, 0, 0, "R2");
        cyc(5, 5, 0, 0, 0, 0, 0, 0, 0, "R2");

        // R3 destructive overflow test
        st(12, "R3");
        cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, 4, 0, 12, 0, 0, 0, 0, 0, "R3");
        cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, "R3");

        // R4 each low selector code
        st(1, "R4"); st(3, "R4");
        for (int k = 0; k < 8; k++) cyc(k, 0, k, 0, 1, 0, 1, 1, 0, "R4");
        for (int k = 0; k < 8; k++) cyc(k, 0, k, 0, 0, 0, 0, 0, 0, "R4");
        st(13, "R4");

        // R6 conditional sets
        cyc(0, 0, 0, 10, 1, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 10, 0, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 11, 0, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 11, 1, 0, 0, 0, 0, "R6");

        // R7 keyboard, parity
        st(9, "R7");
        cyc(0, 0, 0, 9, 0, 0, 0, 0, 1, "R7");
        st(9, "R7");
        st(14, "R7"); st(0, "R7"); st(13, "R7");

        // R8 no-op codes leave flags alone
        st(2, "R8"); st(12, "R8");
        st(0, "R8"); st(15, "R8");
        st(13, "R8"); st(0, "R8"); st(15, "R8");

        // R9 branch sees pre-edge flag values
        cyc(7, 2, 2, 1, 0, 0, 0, 0, 0, "R9");
        cyc(7, 2, 2, 2, 0, 0, 0, 0, 0, "R9");
        cyc(7, 2, 2, 13, 0, 0, 0, 0, 0, "R9");
        cyc(7, 2, 2, 0, 0, 0, 0, 0, 0, "R9");

        // mixed random microwords
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom);
            cyc(r & 511, (r >> 9) & 7, (r >> 12) & 7, (r >> 15) & 15,
                r[19], r[20], r[21], r[22], r[23] & r[24], "R1");
        end

        // R10 reset clears everything
        rst = 1;
        @(posedge clk); @(negedge clk);
        m_addr = 0; m_ovf = 0; m_kbd = 0; m_perr = 0;
        for (int i = 0; i < 4; i++) m_s[i] = 0;
        compare("R10");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule